// File: doc/BRIEF.md
# Interrupt Message Destination Decoder

This block turns 64-bit interrupt message words into pending bits for the local processors. Messages reach it as ordinary register writes, so they stay in order behind earlier link traffic. For each word the block decodes three things: a target selection, a message kind and a vector. It then sets one bit per selected processor. The bit goes into that processor's 256-entry vectored pending register or into its 32-entry mailbox register.

Two write ports feed the same decode path: one for arriving link messages and one for software that injects test messages. A word written on the software port behaves exactly like a link message. Per-bit write-1-to-clear inputs let software acknowledge pending and mailbox bits. A processor can be selected in two ways. In physical mode the destination must equal its ID. In logical mode the destination bit at its ID must be set, which allows multicast and broadcast.

Top module: `irq_msg_decoder`

## Requirements
- R1: After reset every pending bit and every mailbox bit of every processor reads 0.
- R2: A message word carries the vector in bits [7:0], the destination in [15:8], the mode in bit 16 (1 logical, 0 physical) and the kind in [19:17]. Kind 0 sets pending bit `vector` of each selected processor, visible one clock after the write edge.
- R3: In physical mode a processor is selected only when the 8-bit destination equals its ID (IDs 0 and 1 by default). Any other destination value selects nobody.
- R4: In logical mode destination bit N selects the processor with ID N. Several set bits select several processors in the same cycle. A destination of 0, or bits above the local IDs only, selects nobody.
- R5: Word bits [63:20] have no effect, including the extended destination field in [63:40].
- R6: Kind 1 sets mailbox bit `vector mod 32` of each selected processor and leaves its pending register unchanged.
- R7: Kinds 2 to 7 ignore the vector field and set pending bit 246 + kind, which covers bits 248 to 253.
- R8: The software port decodes exactly as the link port does. Words on both ports in the same cycle both take effect.
- R9: A 1 on a clear input clears the matching pending or mailbox bit one clock later. Bits whose clear input is 0 keep their value.
- R10: If a bit is set by a message and cleared in the same cycle, it ends up set.
- R11: Without a message or a clear, all bits hold their value, and new messages add bits without removing earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_vld | input | 1 | Link message write strobe |
| link_word | input | 64 | Link message word |
| sw_vld | input | 1 | Software injection write strobe |
| sw_word | input | 64 | Software injection word |
| pend_clr | input | 512 | Write-1-to-clear for pending bits, processor c at [c*256 +: 256] |
| mbox_clr | input | 64 | Write-1-to-clear for mailbox bits, processor c at [c*32 +: 32] |
| pend_q | output | 512 | Pending registers, processor c at [c*256 +: 256] |
| mbox_q | output | 64 | Mailbox registers, processor c at [c*32 +: 32] |

## Verification
Every result of this block, whether a set from either port, a clear, or a set and clear that collide, shows up at the outputs one clock after the edge that takes the write. The bench drives each stimulus for a single cycle just after a falling edge. For the same step it queues the full expected pending and mailbox image, and the monitor compares that image at the next falling edge, so every comparison lands half a period after the result is due. Idle steps between stimuli queue the unchanged image, which covers the hold behaviour.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int WORD_W = 64;
  localparam int VEC_W  = 8;
  localparam int NVEC   = 1 << VEC_W;
  localparam int MBOX_W = 5;
  localparam int MBOX_N = 1 << MBOX_W;
  localparam int DEST_W = 8;
  localparam logic [VEC_W-1:0] IMPLICIT_BASE = 8'd246;

  typedef enum logic [2:0] {
    KIND_FIXED = 3'd0,
    KIND_MBOX  = 3'd1,
    KIND_SMI   = 3'd2,
    KIND_NMI   = 3'd3,
    KIND_INIT  = 3'd4,
    KIND_START = 3'd5,
    KIND_EXT   = 3'd6,
    KIND_RSVD  = 3'd7
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e          kind;
    logic               logical;
    logic [DEST_W-1:0]  dest;
    logic [VEC_W-1:0]   vec;
  } msg_fields_t;

  function automatic msg_fields_t unpack_word(input logic [WORD_W-1:0] w);
    msg_fields_t f;
    f.vec     = w[7:0];
    f.dest    = w[15:8];
    f.logical = w[16];
    f.kind    = msg_kind_e'(w[19:17]);
    return f;
  endfunction
endpackage

// File: rtl/irq_msg_dec.sv
module irq_msg_dec
  import irq_msg_pkg::*;
#(
  parameter int NCPU        = 2,
  parameter int CPU_ID_BASE = 0
) (
  input  logic                 vld,
  input  logic [WORD_W-1:0]    word,
  output logic [NCPU-1:0]      hit,
  output logic                 to_mbox,
  output logic [VEC_W-1:0]     idx
);
  msg_fields_t f;

  always_comb begin
    f = unpack_word(word);
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam int ID = CPU_ID_BASE + c;
    logic phys_match;
    logic log_match;
    assign phys_match = (f.dest == DEST_W'(ID));
    if (ID < DEST_W) begin : g_log
      assign log_match = f.dest[ID];
    end else begin : g_nolog
      assign log_match = 1'b0;
    end
    assign hit[c] = vld & (f.logical ? log_match : phys_match);
  end

  always_comb begin
    to_mbox = (f.kind == KIND_MBOX);
    if (f.kind == KIND_FIXED || f.kind == KIND_MBOX) begin
      idx = f.vec;
    end else begin
      idx = IMPLICIT_BASE + VEC_W'(f.kind);
    end
  end
endmodule

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = (|set) | (|clr);
    q_nxt = (q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/irq_msg_decoder.sv
module irq_msg_decoder
  import irq_msg_pkg::*;
#(
  parameter int NCPU        = 2,
  parameter int CPU_ID_BASE = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     link_vld,
  input  logic [63:0]              link_word,
  input  logic                     sw_vld,
  input  logic [63:0]              sw_word,
  input  logic [NCPU*256-1:0]      pend_clr,
  input  logic [NCPU*32-1:0]       mbox_clr,
  output logic [NCPU*256-1:0]      pend_q,
  output logic [NCPU*32-1:0]       mbox_q
);
  localparam int NSRC = 2;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  logic [NSRC-1:0]              src_vld;
  logic [NSRC-1:0][WORD_W-1:0]  src_word;
  logic [NSRC-1:0][NCPU-1:0]    src_hit;
  logic [NSRC-1:0]              src_mbox;
  logic [NSRC-1:0][VEC_W-1:0]   src_idx;

  assign src_vld  = {sw_vld, link_vld};
  assign src_word = {sw_word, link_word};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_msg_dec #(.NCPU(NCPU), .CPU_ID_BASE(CPU_ID_BASE)) u_dec (
      .vld     (src_vld[s]),
      .word    (src_word[s]),
      .hit     (src_hit[s]),
      .to_mbox (src_mbox[s]),
      .idx     (src_idx[s])
    );
  end

  logic [NCPU-1:0][NVEC-1:0]   pend_set;
  logic [NCPU-1:0][MBOX_N-1:0] mbox_set;

  always_comb begin
    pend_set = '0;
    mbox_set = '0;
    for (int s = 0; s < NSRC; s++) begin
      for (int c = 0; c < NCPU; c++) begin
        if (src_hit[s][c]) begin
          if (src_mbox[s]) begin
            mbox_set[c][src_idx[s][MBOX_W-1:0]] = 1'b1;
          end else begin
            pend_set[c][src_idx[s]] = 1'b1;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_bank
    irq_w1c_bank #(.W(NVEC)) u_pend (
      .clk   (clk),
      .rst_n (rst_int_n),
      .set   (pend_set[c]),
      .clr   (pend_clr[c*NVEC +: NVEC]),
      .q     (pend_q[c*NVEC +: NVEC])
    );
    irq_w1c_bank #(.W(MBOX_N)) u_mbox (
      .clk   (clk),
      .rst_n (rst_int_n),
      .set   (mbox_set[c]),
      .clr   (mbox_clr[c*MBOX_N +: MBOX_N]),
      .q     (mbox_q[c*MBOX_N +: MBOX_N])
    );
  end
endmodule

// File: rtl/irq_msg_decoder_chk.sv
module irq_msg_decoder_chk #(
  parameter int NCPU        = 2,
  parameter int CPU_ID_BASE = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 link_vld,
  input logic [63:0]          link_word,
  input logic                 sw_vld,
  input logic [NCPU*256-1:0]  pend_clr,
  input logic [NCPU*32-1:0]   mbox_clr,
  input logic [NCPU*256-1:0]  pend_q,
  input logic [NCPU*32-1:0]   mbox_q
);
  localparam int LB = CPU_ID_BASE % 8;

  // R2
  fixed_phys_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_vld && link_word[19:17] == 3'd0 && !link_word[16] &&
     link_word[15:8] == 8'(CPU_ID_BASE))
    |=> pend_q[$past(link_word[7:0])]);

  // R6
  mbox_log_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CPU_ID_BASE < 8 && link_vld && link_word[19:17] == 3'd1 &&
     link_word[16] && link_word[8+LB])
    |=> mbox_q[$past(link_word[4:0])]);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_vld && !sw_vld && pend_clr == '0 && mbox_clr == '0)
    |=> ($stable(pend_q) && $stable(mbox_q)));

  // R9
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_vld && !sw_vld && pend_clr != '0)
    |=> ((pend_q & $past(pend_clr)) == '0));

  // R11
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_vld && !sw_vld)
    |=> ((pend_q & ~$past(pend_q)) == '0 && (mbox_q & ~$past(mbox_q)) == '0));
endmodule

bind irq_msg_decoder irq_msg_decoder_chk #(.NCPU(NCPU), .CPU_ID_BASE(CPU_ID_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .link_vld  (link_vld),
  .link_word (link_word),
  .sw_vld    (sw_vld),
  .pend_clr  (pend_clr),
  .mbox_clr  (mbox_clr),
  .pend_q    (pend_q),
  .mbox_q    (mbox_q)
);

// File: tb/tb_irq_msg_decoder.sv
module tb_irq_msg_decoder;
  logic         clk;
  logic         rst_n;
  logic         link_vld;
  logic [63:0]  link_word;
  logic         sw_vld;
  logic [63:0]  sw_word;
  logic [511:0] pend_clr;
  logic [63:0]  mbox_clr;
  logic [511:0] pend_q;
  logic [63:0]  mbox_q;

  irq_msg_decoder dut (
    .clk(clk), .rst_n(rst_n), .link_vld(link_vld), .link_word(link_word),
    .sw_vld(sw_vld), .sw_word(sw_word), .pend_clr(pend_clr), .mbox_clr(mbox_clr),
    .pend_q(pend_q), .mbox_q(mbox_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [511:0] pend;
    logic [63:0]  mbox;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [511:0] m_pend;
  logic [63:0]  m_mbox;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  function automatic logic [63:0] mkw(input logic [7:0] vec, input logic [7:0] dest,
                                      input bit lg, input logic [2:0] kind,
                                      input logic [43:0] upper);
    return {upper, kind, lg, dest, vec};
  endfunction

  task automatic model_msg(input logic [63:0] w,
                           inout logic [511:0] ps, inout logic [63:0] ms);
    logic [7:0] vec;
    logic [7:0] dest;
    logic [2:0] kind;
    bit         sel;
    vec  = w[7:0];
    dest = w[15:8];
    kind = w[19:17];
    for (int c = 0; c < 2; c++) begin
      sel = w[16] ? dest[c] : (dest == 8'(c));
      if (sel) begin
        if (kind == 3'd1) ms[c*32 + int'(vec[4:0])] = 1'b1;
        else if (kind == 3'd0) ps[c*256 + int'(vec)] = 1'b1;
        else ps[c*256 + 246 + int'(kind)] = 1'b1;
      end
    end
  endtask

  task automatic step(input bit lv, input logic [63:0] lw, input bit sv,
                      input logic [63:0] sw, input logic [511:0] pc,
                      input logic [63:0] mc, input string tag);
    logic [511:0] ps;
    logic [63:0]  ms;
    exp_t e;
    @(negedge clk);
    #1;
    link_vld = lv; link_word = lw; sw_vld = sv; sw_word = sw;
    pend_clr = pc; mbox_clr = mc;
    ps = '0; ms = '0;
    if (lv) model_msg(lw, ps, ms);
    if (sv) model_msg(sw, ps, ms);
    m_pend = (m_pend & ~pc) | ps;
    m_mbox = (m_mbox & ~mc) | ms;
    e.pend = m_pend; e.mbox = m_mbox; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, '0, '0, '0, tag);
  endtask

  task automatic link(input logic [63:0] w, input string tag);
    step(1'b1, w, 1'b0, '0, '0, '0, tag);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (pend_q !== e.pend || mbox_q !== e.mbox) begin
        n_fail++;
        $display("FAIL %s: pend=%h mbox=%h expected pend=%h mbox=%h",
                 e.tag, pend_q, mbox_q, e.pend, e.mbox);
      end
    end
  end

  initial begin
    logic [511:0] pc;
    rst_n = 1'b0;
    link_vld = 1'b0; link_word = '0; sw_vld = 1'b0; sw_word = '0;
    pend_clr = '0; mbox_clr = '0;
    m_pend = '0; m_mbox = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    idle("R1 reset state");
    link(mkw(8'h21, 8'd0, 1'b0, 3'd0, '0), "R2 fixed physical cpu0");
    link(mkw(8'h05, 8'd1, 1'b0, 3'd0, '0), "R3 physical cpu1");
    link(mkw(8'h30, 8'd2, 1'b0, 3'd0, '0), "R3 physical dest 2 none");
    link(mkw(8'h31, 8'h80, 1'b0, 3'd0, '0), "R3 physical dest 0x80 none");
    link(mkw(8'h40, 8'h03, 1'b1, 3'd0, '0), "R4 logical broadcast");
    link(mkw(8'h41, 8'h02, 1'b1, 3'd0, '0), "R4 logical cpu1 only");
    link(mkw(8'h42, 8'h00, 1'b1, 3'd0, '0), "R4 logical empty");
    link(mkw(8'h43, 8'hFC, 1'b1, 3'd0, '0), "R4 logical remote only");
    link(mkw(8'h77, 8'd1, 1'b0, 3'd0, {44{1'b1}}), "R5 upper bits set");
    link(mkw(8'h12, 8'd0, 1'b0, 3'd0, 44'hFFFFFF0_0000), "R5 extended dest");
    link(mkw(8'h25, 8'h01, 1'b1, 3'd1, '0), "R6 mailbox cpu0");
    link(mkw(8'hFF, 8'd1, 1'b0, 3'd1, '0), "R6 mailbox cpu1 wrap");
    for (int k = 2; k < 8; k++) begin
      link(mkw(8'h10, 8'd1, 1'b0, 3'(k), '0), "R7 implicit vector");
    end
    step(1'b0, '0, 1'b1, mkw(8'h99, 8'd0, 1'b0, 3'd0, '0), '0, '0, "R8 software inject");
    step(1'b1, mkw(8'h9A, 8'd1, 1'b0, 3'd0, '0), 1'b1,
         mkw(8'h03, 8'h03, 1'b1, 3'd1, '0), '0, '0, "R8 both ports");
    idle("R11 hold");
    idle("R11 hold again");
    pc = '0; pc[8'h21] = 1'b1; pc[256 + 8'h05] = 1'b1;
    step(1'b0, '0, 1'b0, '0, pc, '0, "R9 pending clear");
    step(1'b0, '0, 1'b0, '0, '0, 64'h0000_0008_0000_0020, "R9 mailbox clear");
    pc = '0; pc[8'h40] = 1'b1;
    step(1'b1, mkw(8'h40, 8'd0, 1'b0, 3'd0, '0), 1'b0, '0, pc, '0, "R10 set wins");
    step(1'b1, mkw(8'h05, 8'h01, 1'b1, 3'd1, '0), 1'b0, '0, '0,
         64'h0000_0000_0000_0020, "R10 mailbox set wins");
    pc = {512{1'b1}};
    step(1'b0, '0, 1'b0, '0, pc, {64{1'b1}}, "R9 clear all");
    idle("R11 final hold");
    idle("drain");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: timeout actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule